// File: doc/BRIEF.md
# Shift-and-Add Precision Extension Stage

This block is the output accumulator that sits behind a bank of four multiply-accumulate filter cells. Each cycle it picks one cell's 26-bit result through a 2-bit address and does one of two things. It either loads that value directly, or it adds the value to its own running sum after shifting that sum right by eight bits. By chaining passes that each produce an 8-bit-wide partial product, the stage builds results for coefficient or sample words wider than 8 bits. The least significant partial product is fed first, and each later one is fed with the earlier total scaled down by 2^8.

The shift is arithmetic when two's complement arithmetic is selected and logical when unsigned arithmetic is selected. The 26-bit result leaves on a bus split into a low part and a high part. Each part has its own enable, and a disabled part reads as zero. A synchronous reset empties the accumulator. The partial products themselves are computed elsewhere.

Top module: `shadd_stage`

## Requirements
- R1: While `rst` is high at a rising clock edge, the accumulator is cleared to zero. With both output enables high, `result` reads 0 after that edge.
- R2: With `shift_add` low, one clock edge after inputs are applied the accumulator equals the selected cell value exactly.
- R3: `cell_sel` value k (0 to 3) selects bits [26*k+25 : 26*k] of `cell_acc`.
- R4: With `shift_add` high, the next accumulator value is the selected cell value plus the current accumulator shifted right by 8 bits.
- R5: With `signed_mode` high, the 8-bit right shift fills the vacated upper 8 bits with copies of accumulator bit 25.
- R6: With `signed_mode` low, the 8-bit right shift fills the vacated upper 8 bits with zeros.
- R7: The sum in R4 is taken modulo 2^26, and carries out of bit 25 are dropped.
- R8: `result[15:0]` shows accumulator bits [15:0] when `oe_lo` is high, and reads zero when it is low, without changing the accumulator.
- R9: `result[25:16]` shows accumulator bits [25:16] when `oe_hi` is high, and reads zero when it is low, without changing the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cell_acc | input | 104 | Four packed 26-bit cell results, cell k at bits [26k+25:26k] |
| cell_sel | input | 2 | Selects which cell result feeds the stage |
| shift_add | input | 1 | 1: add to shifted running sum; 0: load |
| signed_mode | input | 1 | 1: arithmetic shift; 0: logical shift |
| oe_lo | input | 1 | Enables the low 16 output bits |
| oe_hi | input | 1 | Enables the high 10 output bits |
| result | output | 26 | Accumulator value, gated per part |

## Verification
The assertions check several behaviours on every cycle. They confirm that reset empties the accumulator and that a load copies the addressed cell exactly. They check that the vacated top byte after a shift carries the sign or zeros as the mode dictates, and that a disabled output part is zero. The bench scenarios show the behaviours that need a chain of values. These are full multi-pass precision extension, the selection of each of the four addresses, wraparound past bit 25, and the fact that toggling the output enables leaves the stored sum intact.

// File: rtl/shadd_stage.sv
module shadd_stage #(
  parameter int W      = 26,
  parameter int NCELL  = 4,
  parameter int SH     = 8,
  parameter int LO_W   = 16,
  localparam int SEL_W = $clog2(NCELL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCELL*W-1:0] cell_acc,
  input  logic [SEL_W-1:0]   cell_sel,
  input  logic               shift_add,
  input  logic               signed_mode,
  input  logic               oe_lo,
  input  logic               oe_hi,
  output logic [W-1:0]       result
);

  logic [W-1:0] acc;
  logic [W-1:0] cur_cell;
  logic [W-1:0] scaled;

  assign cur_cell = cell_acc[cell_sel*W +: W];
  assign scaled   = signed_mode ? W'($signed(acc) >>> SH) : (acc >> SH);

  always_ff @(posedge clk) begin
    if (rst)            acc <= '0;
    else if (shift_add) acc <= cur_cell + scaled;
    else                acc <= cur_cell;
  end

  assign result = {oe_hi ? acc[W-1:LO_W] : '0, oe_lo ? acc[LO_W-1:0] : '0};

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> acc == '0);

  a_r2_load_exact: assert property (@(posedge clk) disable iff (rst)
    !shift_add |=> acc == $past(cur_cell));

  a_r5_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (shift_add && signed_mode && cur_cell == '0 && acc[W-1]) |=> acc[W-1 -: SH] == '1);

  a_r6_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (shift_add && !signed_mode && cur_cell == '0) |=> acc[W-1 -: SH] == '0);

  always_comb begin
    if (!oe_lo) a_r8_lo_off: assert (result[LO_W-1:0] == '0);
    if (!oe_hi) a_r9_hi_off: assert (result[W-1:LO_W] == '0);
  end

endmodule

// File: tb/shadd_stage_bench.sv
`timescale 1ns/1ps
module shadd_stage_bench;
  localparam int W = 26;
  localparam int N = 4;
  localparam int SH = 8;
  localparam int LO = 16;

  logic clk = 0;
  logic rst = 1;
  logic [N*W-1:0] cell_acc = '0;
  logic [1:0] cell_sel = 0;
  logic shift_add = 0, signed_mode = 0, oe_lo = 1, oe_hi = 1;
  logic [W-1:0] result;

  int total = 0, bad = 0;
  bit done = 0;
  logic [W-1:0] model;

  always #2 clk = ~clk;

  shadd_stage u_shadd_stage (
    .clk(clk), .rst(rst), .cell_acc(cell_acc), .cell_sel(cell_sel),
    .shift_add(shift_add), .signed_mode(signed_mode),
    .oe_lo(oe_lo), .oe_hi(oe_hi), .result(result));

  function automatic logic [W-1:0] shr8(input logic [W-1:0] v, input logic sgn);
    logic [W-1:0] r;
    r = v >> SH;
    if (sgn && v[W-1]) r[W-1 -: SH] = '1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] sel, input logic sa, input logic sm);
    @(negedge clk);
    cell_sel = sel; shift_add = sa; signed_mode = sm;
    model = sa ? (cell_acc[sel*W +: W] + shr8(model, sm)) : cell_acc[sel*W +: W];
    @(posedge clk); #1;
  endtask

  task automatic set_cells(input logic [W-1:0] c0, c1, c2, c3);
    @(negedge clk);
    cell_acc = {c3, c2, c1, c0};
  endtask

  task automatic t_reset;
    set_cells(26'h1234567, 26'h2AAAAAA, 26'h0155555, 26'h3FFFFFF);
    shift_add = 1; rst = 1;
    @(posedge clk); @(posedge clk); #1;
    chk("R1 reset clears", result, '0);
    @(negedge clk); rst = 0; model = '0;
  endtask

  task automatic t_load;
    set_cells(26'h0000011, 26'h2345678, 26'h3000001, 26'h1ABCDEF);
    for (int k = 0; k < N; k++) begin
      step(2'(k), 0, 0);
      chk($sformatf("R2 R3 load sel=%0d", k), result, model);
    end
    step(3, 0, 1);
    chk("R2 load ignores signed_mode", result, 26'h1ABCDEF);
  endtask

  task automatic t_signed;
    set_cells(26'h0000000, 26'h2800000, 26'h0000005, 26'h0000000);
    step(1, 0, 1);
    step(0, 1, 1);
    chk("R5 sign fill", result, 26'h3FE8000);
    step(2, 1, 1);
    chk("R4 R5 add after arith shift", result, model);
    chk("R4 value", result, 26'h3FFFE85);
  endtask

  task automatic t_unsigned;
    set_cells(26'h0000000, 26'h2800000, 26'h0000007, 26'h0000000);
    step(1, 0, 0);
    step(0, 1, 0);
    chk("R6 zero fill", result, 26'h0028000);
    step(2, 1, 0);
    chk("R4 R6 add after logical shift", result, 26'h0000287);
  endtask

  task automatic t_multipass;
    set_cells(26'h0012345, 26'h0023456, 26'h0034567, 26'h0045678);
    step(0, 0, 0);
    step(1, 1, 0);
    step(2, 1, 0);
    step(3, 1, 0);
    chk("R4 R3 four pass chain", result, model);
    chk("R4 chain value", result, 26'h00459BF);
  endtask

  task automatic t_wrap;
    set_cells(26'h3FFFFFF, 26'h0000000, 26'h0000000, 26'h0000000);
    step(0, 0, 0);
    step(0, 1, 0);
    chk("R7 modulo wrap", result, 26'h003FFFE);
  endtask

  task automatic t_enables;
    set_cells(26'h2ABCDEF, 26'h0, 26'h0, 26'h0);
    step(0, 0, 0);
    @(negedge clk); oe_lo = 0; #1;
    chk("R8 low off", result, 26'h2AB0000);
    oe_hi = 0; #1;
    chk("R9 both off", result, '0);
    oe_lo = 1; #1;
    chk("R9 high off", result, 26'h000CDEF);
    oe_hi = 1;
    @(posedge clk); #1;
    chk("R8 R9 sum kept", result, 26'h2ABCDEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model = '0;
    t_reset();
    t_load();
    t_signed();
    t_unsigned();
    t_multipass();
    t_wrap();
    t_enables();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule